// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory

This block is a small synchronous RAM for 8-bit words that protects every stored word with four Hamming check bits. On a write, the data byte is encoded into a 12-bit codeword and stored. On a read, the stored codeword is decoded: the check bits are recomputed from the stored data and compared with the stored ones. A single flipped data bit is repaired before the byte leaves the block, and a flag reports what the decoder saw.

A separate fault-injection port XORs a 12-bit mask into any stored codeword, without re-encoding. Benches use it to plant single or multiple bit faults. The depth is set by the address width parameter. The data width is fixed at eight bits, because the codeword layout is tied to it: 2^K − 1 ≥ 8 + K gives K = 4.

Top module: `ecc_word_mem`

## Requirements
- R1: A byte written to an address is returned unchanged by a later read of that address, with all three error flags low, provided no fault was injected in between.
- R2: The stored codeword uses positions 1 to 12, held in codeword bits 0 to 11. Check bits sit at positions 1, 2, 4 and 8. Data bits wrData[0] to wrData[7] sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Each check bit is the XOR of the data positions whose number has a 1 in the same binary place as the check bit's position. For example, byte 0x01 encodes to 12'h007 and byte 0x80 encodes to 12'h888.
- R3: The syndrome is the XOR of the stored check bits with the recomputed check bits, with syndrome bit k belonging to position 2^k. When the syndrome is zero, the stored data is output as is and no flag is raised.
- R4: When the syndrome equals the position of a data bit (3, 5, 6, 7, 9, 10, 11 or 12), that data bit is inverted on output and errCorrected is high.
- R5: When the syndrome has exactly one bit set, errCheckBit is high and the stored data is output without change.
- R6: When the syndrome is 13, 14 or 15, errUncorrectable is high and the raw stored data bits are output.
- R7: A read sampled at a clock edge makes rdData and the flags valid after that edge, with rdValid high for exactly that one cycle. While rdValid is low, all flags are low and rdData holds its last value. At most one flag is high at a time.
- R8: A read in the same cycle as a write or an injection to the same address returns the contents from before that cycle. A write and an injection to the same address in the same cycle store the freshly encoded write data, and the injection is dropped. Injection XORs its mask into the stored codeword without re-encoding.
- R9: Reset clears every word to the all-zero codeword, so a read after reset returns 0x00 with no flag.
- R10: Injecting the same mask twice into one address restores the original codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Address for read and write |
| wrData | input | 8 | Byte to store |
| rdData | output | 8 | Decoded byte from the last read |
| rdValid | output | 1 | One-cycle pulse marking a read result |
| errCorrected | output | 1 | A data bit was repaired |
| errCheckBit | output | 1 | A single check bit was wrong; data untouched |
| errUncorrectable | output | 1 | Syndrome points past position 12 |
| injEn | input | 1 | Fault-injection strobe |
| injAddr | input | ADDR_W | Word to inject into |
| injMask | input | 12 | Bits of the codeword to flip |

## Verification
The bench builds the block with ADDR_W = 3, giving eight words. At that size it can plant a fault at every one of the twelve codeword positions in every word and then remove each fault again, so every syndrome from 1 to 12 is decoded at every address. Paired-bit masks drive syndromes 13 to 15. Hand-made codewords pin down the bit layout. Same-cycle write, read and injection collisions are also covered at this depth.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CODE_W = DATA_W + CHK_W;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
    logic injStb;
  } memCmd_t;

  typedef struct packed {
    logic uncorrectable;
    logic checkBit;
    logic corrected;
  } eccFlags_t;

  function automatic logic isPow2(input int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // Codeword position (1-based) of data bit idx.
  function automatic int dataPos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CHK_W-1:0] calcCheck(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] chk;
    int p;
    chk = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = dataPos(i);
      for (int k = 0; k < CHK_W; k++) begin
        if (p[k]) chk[k] = chk[k] ^ d[i];
      end
    end
    return chk;
  endfunction

  function automatic logic [CODE_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] code;
    logic [CHK_W-1:0]  chk;
    code = '0;
    chk  = calcCheck(d);
    for (int i = 0; i < DATA_W; i++) code[dataPos(i)-1] = d[i];
    for (int k = 0; k < CHK_W; k++) code[(1 << k) - 1] = chk[k];
    return code;
  endfunction

  function automatic logic [DATA_W-1:0] pickData(input logic [CODE_W-1:0] code);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = code[dataPos(i)-1];
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] pickCheck(input logic [CODE_W-1:0] code);
    logic [CHK_W-1:0] c;
    for (int k = 0; k < CHK_W; k++) c[k] = code[(1 << k) - 1];
    return c;
  endfunction

endpackage

// File: rtl/ecc_syndrome_dec.sv
module ecc_syndrome_dec
  import ecc_pkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  output logic [DATA_W-1:0] dataOut,
  output eccFlags_t         flagsOut
);

  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  storedChk;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] flipMask;
  logic              synIsPow2;

  assign rawData   = pickData(codeIn);
  assign storedChk = pickCheck(codeIn);
  assign syndrome  = storedChk ^ calcCheck(rawData);

  // One comparator per data bit against its own position number.
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int POS = dataPos(i);
    assign flipMask[i] = (syndrome == CHK_W'(POS));
  end

  assign synIsPow2 = (syndrome != '0) && ((syndrome & (syndrome - CHK_W'(1))) == '0);

  always_comb begin
    flagsOut               = '0;
    flagsOut.corrected     = |flipMask;
    flagsOut.checkBit      = synIsPow2;
    flagsOut.uncorrectable = (syndrome > CHK_W'(CODE_W));
    dataOut                = rawData ^ flipMask;
  end

endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] injAddr,
  output memCmd_t           cmd,
  output logic              rdValid
);

  logic injCollide;
  logic rdValidQ;

  // A write to the injected word in the same cycle wins.
  assign injCollide = wrEn && (addr == injAddr);

  always_comb begin
    cmd        = '0;
    cmd.wrStb  = wrEn;
    cmd.rdStb  = rdEn;
    cmd.injStb = injEn && !injCollide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= rdEn;
  end

  assign rdValid = rdValidQ;

endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memCmd_t           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [CODE_W-1:0] injMask,
  output logic [DATA_W-1:0] rdData,
  output eccFlags_t         rdFlags
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [CODE_W-1:0] rdCode;
  logic [DATA_W-1:0] decData;
  eccFlags_t         decFlags;
  logic [DATA_W-1:0] rdDataQ;
  eccFlags_t         rdFlagsQ;

  // Storage: write and injection never target the same word here.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (cmd.wrStb)  mem[addr]    <= encode(wrData);
      if (cmd.injStb) mem[injAddr] <= mem[injAddr] ^ injMask;
    end
  end

  assign rdCode = mem[addr];

  ecc_syndrome_dec u_dec (
    .codeIn   (rdCode),
    .dataOut  (decData),
    .flagsOut (decFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdFlagsQ <= '0;
    end else begin
      if (cmd.rdStb) rdDataQ <= decData;
      rdFlagsQ <= cmd.rdStb ? decFlags : '0;
    end
  end

  assign rdData  = rdDataQ;
  assign rdFlags = rdFlagsQ;

endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              errCorrected,
  output logic              errCheckBit,
  output logic              errUncorrectable,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [11:0]       injMask
);

  memCmd_t   cmd;
  eccFlags_t rdFlags;

  ecc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .injEn   (injEn),
    .addr    (addr),
    .injAddr (injAddr),
    .cmd     (cmd),
    .rdValid (rdValid)
  );

  ecc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .addr    (addr),
    .wrData  (wrData),
    .injAddr (injAddr),
    .injMask (injMask),
    .rdData  (rdData),
    .rdFlags (rdFlags)
  );

  assign errCorrected     = rdFlags.corrected;
  assign errCheckBit      = rdFlags.checkBit;
  assign errUncorrectable = rdFlags.uncorrectable;

endmodule

// File: rtl/ecc_word_mem_chk.sv
module ecc_word_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              rdValid,
  input logic              errCorrected,
  input logic              errCheckBit,
  input logic              errUncorrectable
);

  // R7: a sampled read yields a valid pulse on the next cycle
  p_valid_follows_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R7: no valid pulse without a read
  p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R7: flags stay low outside a valid cycle
  p_flags_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !(errCorrected || errCheckBit || errUncorrectable));

  // R7: at most one flag at a time
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errCorrected, errCheckBit, errUncorrectable}));

  // R7: read data holds when no read happened
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R1: write followed at once by a read of the same word returns it cleanly
  p_write_readback_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn ##1 (rdEn && (addr == $past(addr))) |=>
      (rdData == $past(wrData, 2)) && !errCorrected && !errCheckBit && !errUncorrectable);

endmodule

bind ecc_word_mem ecc_word_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .wrEn             (wrEn),
  .rdEn             (rdEn),
  .addr             (addr),
  .wrData           (wrData),
  .rdData           (rdData),
  .rdValid          (rdValid),
  .errCorrected     (errCorrected),
  .errCheckBit      (errCheckBit),
  .errUncorrectable (errUncorrectable)
);

// File: tb/ecc_word_mem_tb.sv
`timescale 1ns/1ps
module ecc_word_mem_tb;

  localparam int AW = 3;
  localparam int NW = 1 << AW;
  localparam logic [2:0] F_NONE = 3'b000;
  localparam logic [2:0] F_COR  = 3'b001;
  localparam logic [2:0] F_CHK  = 3'b010;
  localparam logic [2:0] F_UNC  = 3'b100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0, injEn = 1'b0;
  logic [AW-1:0] addr = '0, injAddr = '0;
  logic [7:0]    wrData = '0;
  logic [11:0]   injMask = '0;
  logic [7:0]    rdData;
  logic          rdValid, errCorrected, errCheckBit, errUncorrectable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] expD[$];
  logic [2:0] expF[$];
  string      expT[$];

  always #2 clk = ~clk;

  ecc_word_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .errCorrected(errCorrected), .errCheckBit(errCheckBit),
    .errUncorrectable(errUncorrectable),
    .injEn(injEn), .injAddr(injAddr), .injMask(injMask)
  );

  // Encoder written from the R2 equations.
  function automatic logic [11:0] enc(input logic [7:0] d);
    logic [11:0] c;
    c[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2]  = d[0];
    c[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[4]  = d[1];
    c[5]  = d[2];
    c[6]  = d[3];
    c[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    c[8]  = d[4];
    c[9]  = d[5];
    c[10] = d[6];
    c[11] = d[7];
    return c;
  endfunction

  function automatic logic [11:0] pm(input int p);
    return 12'(1) << (p - 1);
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'hA5 ^ 8'(a * 29);
  endfunction

  function automatic bit pow2(input int p);
    return (p == 1) || (p == 2) || (p == 4) || (p == 8);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor, samples on the falling edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rdValid) begin
        if (expD.size() == 0) begin
          check(1'b0, "R7 unexpected rdValid", 12'(rdData), 12'h0);
        end else begin
          logic [7:0] d;
          logic [2:0] f;
          string      t;
          d = expD.pop_front();
          f = expF.pop_front();
          t = expT.pop_front();
          checks++;
          if (rdData !== d || {errUncorrectable, errCheckBit, errCorrected} !== f) begin
            fails++;
            $display("FAIL %s: data=%h flags=%b expected data=%h flags=%b",
                     t, rdData, {errUncorrectable, errCheckBit, errCorrected}, d, f);
          end
        end
      end else if (errCorrected || errCheckBit || errUncorrectable) begin
        check(1'b0, "R7 flag without rdValid",
              12'({errUncorrectable, errCheckBit, errCorrected}), 12'h0);
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic i,
                    input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [AW-1:0] ia, input logic [11:0] m,
                    input logic [7:0] eD, input logic [2:0] eF, input string tag);
    @(negedge clk);
    wrEn = w; rdEn = r; injEn = i;
    addr = a; wrData = d; injAddr = ia; injMask = m;
    if (r) begin
      expD.push_back(eD); expF.push_back(eF); expT.push_back(tag);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; injEn = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    op(1'b1, 1'b0, 1'b0, AW'(a), d, '0, '0, '0, F_NONE, "");
  endtask

  task automatic rd(input int a, input logic [7:0] eD, input logic [2:0] eF, input string tag);
    op(1'b0, 1'b1, 1'b0, AW'(a), '0, '0, '0, eD, eF, tag);
  endtask

  task automatic inj(input int a, input logic [11:0] m);
    op(1'b0, 1'b0, 1'b1, '0, '0, AW'(a), m, '0, F_NONE, "");
  endtask

  task automatic finishRun();
    done = 1'b1;
    if (expD.size() != 0) check(1'b0, "R7 missing read results", 12'(expD.size()), 12'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [7:0] d2;
    repeat (3) @(negedge clk);
    check(rdValid === 1'b0 && {errUncorrectable, errCheckBit, errCorrected} === 3'b000,
          "R9 outputs in reset", {8'h0, rdValid, errUncorrectable, errCheckBit, errCorrected}, 12'h0);
    rstN = 1'b1;

    // R9: cleared words after reset
    for (int a = 0; a < NW; a++) rd(a, 8'h00, F_NONE, "R9 cleared word");

    // R1 / R3: clean write and readback
    for (int a = 0; a < NW; a++) wr(a, pat(a));
    for (int a = 0; a < NW; a++) rd(a, pat(a), F_NONE, "R1 R3 clean readback");

    // R4 / R5 / R10: every single-position fault, then removed again
    for (int a = 0; a < NW; a++) begin
      for (int p = 1; p <= 12; p++) begin
        inj(a, pm(p));
        if (pow2(p)) rd(a, pat(a), F_CHK, "R5 check-bit fault");
        else         rd(a, pat(a), F_COR, "R4 data-bit fault");
        inj(a, pm(p));
        rd(a, pat(a), F_NONE, "R10 double injection restores");
      end
    end

    // R2: fixed codewords and re-encoding through injection
    wr(7, 8'h00);
    inj(7, 12'h007);
    rd(7, 8'h01, F_NONE, "R2 codeword 007 reads 0x01");
    inj(7, 12'h007 ^ 12'h888);
    rd(7, 8'h80, F_NONE, "R2 codeword 888 reads 0x80");
    wr(7, pat(7));
    for (int a = 0; a < 4; a++) begin
      d2 = ~pat(a) ^ 8'(a << 2);
      inj(a, enc(pat(a)) ^ enc(d2));
      rd(a, d2, F_NONE, "R2 injected valid codeword");
      inj(a, enc(pat(a)) ^ enc(d2));
    end

    // R6: syndromes past the last position
    inj(5, pm(12) | pm(1));  rd(5, pat(5) ^ 8'h80, F_UNC, "R6 syndrome 13");  inj(5, pm(12) | pm(1));
    inj(5, pm(12) | pm(2));  rd(5, pat(5) ^ 8'h80, F_UNC, "R6 syndrome 14");  inj(5, pm(12) | pm(2));
    inj(5, pm(12) | pm(3));  rd(5, pat(5) ^ 8'h81, F_UNC, "R6 syndrome 15");  inj(5, pm(12) | pm(3));
    inj(5, pm(9)  | pm(4));  rd(5, pat(5) ^ 8'h10, F_UNC, "R6 syndrome 13b"); inj(5, pm(9)  | pm(4));
    inj(5, pm(10) | pm(4));  rd(5, pat(5) ^ 8'h20, F_UNC, "R6 syndrome 14b"); inj(5, pm(10) | pm(4));
    inj(5, pm(11) | pm(4));  rd(5, pat(5) ^ 8'h40, F_UNC, "R6 syndrome 15b"); inj(5, pm(11) | pm(4));
    rd(5, pat(5), F_NONE, "R10 word 5 restored");

    // R8: same-cycle collisions
    op(1'b1, 1'b0, 1'b1, AW'(3), 8'h5A, AW'(3), pm(5), '0, F_NONE, "");
    rd(3, 8'h5A, F_NONE, "R8 write beats injection");
    op(1'b1, 1'b0, 1'b1, AW'(4), 8'hC3, AW'(6), pm(6), '0, F_NONE, "");
    rd(4, 8'hC3, F_NONE, "R8 write beside injection");
    rd(6, pat(6), F_COR, "R8 injection beside write");
    inj(6, pm(6));
    op(1'b1, 1'b1, 1'b0, AW'(0), 8'h77, '0, '0, pat(0), F_NONE, "R8 read before write");
    rd(0, 8'h77, F_NONE, "R8 write landed");
    op(1'b0, 1'b1, 1'b1, AW'(1), '0, AW'(1), pm(7), pat(1), F_NONE, "R8 read before injection");
    rd(1, pat(1), F_COR, "R8 injection landed");
    inj(1, pm(7));

    // R7: back-to-back reads, then hold
    @(negedge clk);
    rdEn = 1'b1; addr = AW'(2);
    expD.push_back(pat(2)); expF.push_back(F_NONE); expT.push_back("R7 back-to-back first");
    @(negedge clk);
    addr = AW'(6);
    expD.push_back(pat(6)); expF.push_back(F_NONE); expT.push_back("R7 back-to-back second");
    @(negedge clk);
    rdEn = 1'b0; addr = AW'(0);
    repeat (3) @(negedge clk);
    check(rdValid === 1'b0 && rdData === pat(6), "R7 data held while idle",
          {3'b0, rdValid, rdData}, {4'b0, pat(6)});

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule